// File: doc/BRIEF.md
# Cascadable Offset-Range Binary Counter

The block is a synchronous binary up-counter built from identical 4-bit slices. Each slice has a clear, a parallel load and a count enable, all synchronous. It also has a carry output that lets a wider counter be formed by chaining slices. Two slices are chained into an 8-bit counter, and the carry of each slice enables the next one.

A separate slice in the same block is wrapped with a compare and reload path, which turns it into a counter with a programmable first and last value. The counter advances up to a chosen end value. On the next clock it re-seeds itself with a chosen start value through the load path, so it cycles over an arbitrary sub-range of the 4-bit space.

The clear input is shared by both counters and acts as the block's reset.

Top module: `span_counter`

## Requirements
- R1: When `clr` is high at a rising clock edge, `count` becomes 0 and `ofs_count` becomes 0. This happens regardless of `load`, `en` and `ofs_en`.
- R2: When `load` is high and `clr` is low at a rising edge, `count` takes the value of `load_data` (bit 7 most significant). No increment happens in that cycle, even if `en` is high.
- R3: When `clr` and `load` are low, `count` increases by one modulo 256 at each rising edge with `en` high. It holds its value when `en` is low.
- R4: `carry_out` is high exactly when `en` is high and `count` is 8'hFF.
- R5: The upper nibble of `count` increments only on an edge where the lower nibble is 4'hF and counting is enabled. A count of 8'hFF wraps to 8'h00.
- R6: With `ofs_en` high and `clr` low, `ofs_count` increments by one modulo 16 at each edge. The exception is when `ofs_count` equals `ofs_end`: at that edge it takes `ofs_start` instead.
- R7: `ofs_at_end` is high exactly when `ofs_count` equals `ofs_end`.
- R8: With `ofs_en` low, `ofs_count` holds, including when it sits at `ofs_end`.
- R9: When `ofs_start` is above `ofs_end`, or the counter lies above `ofs_end`, the offset counter rolls over from 15 to 0 and continues up to `ofs_end`. When start equals end, it stays at that value while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of both counters, highest priority |
| en | input | 1 | Count enable of the 8-bit cascade |
| load | input | 1 | Synchronous parallel load of the 8-bit cascade |
| load_data | input | 8 | Value loaded into the cascade |
| count | output | 8 | Cascade count value |
| carry_out | output | 1 | High when enabled at the all-ones count |
| ofs_en | input | 1 | Count enable of the offset counter |
| ofs_start | input | 4 | Value re-seeded after the end value |
| ofs_end | input | 4 | Last value before the re-seed |
| ofs_count | output | 4 | Offset counter value |
| ofs_at_end | output | 1 | High while the offset counter equals `ofs_end` |

## Verification
The bench loads 8'hFE and steps through 8'hFF to 8'h00. A carry that is not gated by enable, or a chain that lets the upper nibble tick on every edge, shows up there as a wrong upper nibble or a stray carry. A full 256-step run catches any slice that increments out of step.

Clear and load are driven together with enable. An inverted priority would leave a loaded value after a clear, or a value one above the loaded data.

The offset counter is checked over several start and end pairs against a model, including start above end and start equal to end. A design that clears to zero at the end value, or re-seeds one cycle late, drifts from the model within one period. Holding `ofs_en` low at the end value catches a reload that ignores the enable.

// File: rtl/span_counter.sv
module bin_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         rco
);
  always_ff @(posedge clk) begin
    if (clr)      q <= '0;
    else if (ld)  q <= din;
    else if (en)  q <= q + 1'b1;
  end

  assign rco = en & (&q);

  p_clear_r1: assert property (@(posedge clk) clr |=> q == '0);
  p_load_r2: assert property (@(posedge clk) disable iff (clr)
    ld |=> q == $past(din));
  p_count_r3: assert property (@(posedge clk) disable iff (clr)
    (!ld && en) |=> q == W'($past(q) + 1'b1));
  p_hold_r3: assert property (@(posedge clk) disable iff (clr)
    (!ld && !en) |=> $stable(q));
endmodule

module span_counter #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2,
  localparam int WIDE   = SLICE_W * SLICES
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               en,
  input  logic               load,
  input  logic [WIDE-1:0]    load_data,
  output logic [WIDE-1:0]    count,
  output logic               carry_out,
  input  logic               ofs_en,
  input  logic [SLICE_W-1:0] ofs_start,
  input  logic [SLICE_W-1:0] ofs_end,
  output logic [SLICE_W-1:0] ofs_count,
  output logic               ofs_at_end
);
  logic [SLICES:0] chain;
  assign chain[0] = en;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    bin_slice #(.W(SLICE_W)) u_slice (
      .clk (clk),
      .clr (clr),
      .ld  (load),
      .en  (chain[i]),
      .din (load_data[i*SLICE_W +: SLICE_W]),
      .q   (count[i*SLICE_W +: SLICE_W]),
      .rco (chain[i+1])
    );
    if (i > 0) begin : g_chk
      p_cascade_r5: assert property (@(posedge clk) disable iff (clr)
        (!load && en && (&count[i*SLICE_W-1:0]))
        |=> count[i*SLICE_W +: SLICE_W] ==
            SLICE_W'($past(count[i*SLICE_W +: SLICE_W]) + 1'b1));
    end
  end

  assign carry_out = chain[SLICES];

  assign ofs_at_end = (ofs_count == ofs_end);

  logic ofs_unused_rco;
  bin_slice #(.W(SLICE_W)) u_ofs (
    .clk (clk),
    .clr (clr),
    .ld  (ofs_en & ofs_at_end),
    .en  (ofs_en),
    .din (ofs_start),
    .q   (ofs_count),
    .rco (ofs_unused_rco)
  );

  p_carry_r4: assert property (@(posedge clk) disable iff (clr)
    carry_out |-> (en && (&count)));
  p_wrap_r6: assert property (@(posedge clk) disable iff (clr)
    (ofs_en && ofs_count == ofs_end) |=> ofs_count == $past(ofs_start));
  p_idle_r8: assert property (@(posedge clk) disable iff (clr)
    !ofs_en |=> $stable(ofs_count));
endmodule

// File: tb/span_counter_tb.sv
module span_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr, en, load, ofs_en;
  logic [7:0] load_data;
  logic [3:0] ofs_start, ofs_end;
  logic [7:0] count;
  logic       carry_out;
  logic [3:0] ofs_count;
  logic       ofs_at_end;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  span_counter dut_i (
    .clk(clk), .clr(clr), .en(en), .load(load), .load_data(load_data),
    .count(count), .carry_out(carry_out), .ofs_en(ofs_en),
    .ofs_start(ofs_start), .ofs_end(ofs_end), .ofs_count(ofs_count),
    .ofs_at_end(ofs_at_end)
  );

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0h want %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs;
    @(negedge clk);
    clr = 0; en = 0; load = 0; ofs_en = 0;
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr = 1; load = 1; load_data = 8'h5A; en = 1; ofs_en = 1;
    tick();
    check("R1 count", count, 0);
    check("R1 ofs_count", ofs_count, 0);
    idle_inputs();
  endtask

  task automatic t_load;
    @(negedge clk);
    load = 1; en = 1; load_data = 8'h3C;
    tick();
    check("R2 load over enable", count, 8'h3C);
    @(negedge clk);
    load = 0; en = 0;
    tick();
    check("R3 hold", count, 8'h3C);
    @(negedge clk);
    en = 1;
    tick();
    check("R3 step", count, 8'h3D);
    tick();
    check("R3 step2", count, 8'h3E);
    idle_inputs();
  endtask

  task automatic t_carry_wrap;
    @(negedge clk);
    load = 1; load_data = 8'hFE;
    tick();
    @(negedge clk);
    load = 0; en = 1;
    #1 check("R4 carry below FF", carry_out, 0);
    tick();
    check("R5 to FF", count, 8'hFF);
    check("R4 carry at FF", carry_out, 1);
    @(negedge clk);
    en = 0;
    #1 check("R4 carry gated by en", carry_out, 0);
    @(negedge clk);
    en = 1;
    tick();
    check("R5 wrap", count, 8'h00);
    check("R4 carry after wrap", carry_out, 0);
    idle_inputs();
  endtask

  task automatic t_full_run;
    logic [7:0] m;
    @(negedge clk);
    load = 1; load_data = 8'h00;
    tick();
    m = 8'h00;
    @(negedge clk);
    load = 0; en = 1;
    for (int k = 0; k < 260; k++) begin
      tick();
      m = m + 1;
      if (count != m) check("R5 full run", count, m);
      else vectors++;
    end
    check("R5 full run end", count, m);
    idle_inputs();
  endtask

  task automatic t_offset(input logic [3:0] s, input logic [3:0] e);
    logic [3:0] m;
    @(negedge clk);
    clr = 1; ofs_start = s; ofs_end = e;
    tick();
    m = 0;
    @(negedge clk);
    clr = 0; ofs_en = 1;
    for (int k = 0; k < 40; k++) begin
      #1 check("R7 at_end", ofs_at_end, (m == e));
      tick();
      m = (m == e) ? s : m + 1;
      check((s > e || s == e) ? "R9 range" : "R6 range", ofs_count, m);
      @(negedge clk);
    end
    idle_inputs();
  endtask

  task automatic t_offset_hold;
    @(negedge clk);
    clr = 1; ofs_start = 4'h2; ofs_end = 4'h4;
    tick();
    @(negedge clk);
    clr = 0; ofs_en = 1;
    repeat (4) tick();
    check("R6 reach end", ofs_count, 4'h4);
    @(negedge clk);
    ofs_en = 0;
    repeat (3) tick();
    check("R8 hold at end", ofs_count, 4'h4);
    @(negedge clk);
    ofs_en = 1;
    tick();
    check("R6 reseed", ofs_count, 4'h2);
    idle_inputs();
  endtask

  initial begin
    clr = 1; en = 0; load = 0; ofs_en = 0; load_data = 0;
    ofs_start = 0; ofs_end = 0;
    tick();
    check("R1 reset count", count, 0);
    check("R1 reset ofs", ofs_count, 0);
    idle_inputs();
    t_clear();
    t_load();
    t_carry_wrap();
    t_full_run();
    t_offset(4'h6, 4'hD);
    t_offset(4'h0, 4'h5);
    t_offset(4'hA, 4'h3);
    t_offset(4'h3, 4'h3);
    t_offset_hold();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    misses++;
    $display("FAIL watchdog: got timeout want completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule